// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit carries out one of four operations on a single bit of an operand that has already been fetched: a pure test, or a test followed by forcing the bit high, forcing it low, or inverting it. The operand is either a 32-bit register value or an 8-bit memory byte. The bit number comes from an immediate field or from a data register. Both sources arrive on the same input and take the same path.

A one-cycle start strobe latches the request. On the next clock the unit presents the operand with the chosen bit modified, a write-back enable, the condition flags with the zero flag updated, and a one-cycle done pulse. The zero flag always records the addressed bit as it stood before the modification. Address calculation, bus cycles and decode belong to the surrounding pipeline.

Top module: `bit_op_unit`

## Requirements
- R1: While reset is held, and after it is released, resultOut, flagsOut, wbEnOut and doneOut are all zero until the first start.
- R2: On every operation, bit 2 of flagsOut (the zero flag) is 1 if the addressed bit of the operand was 0 and 0 if it was 1, judged before any modification.
- R3: opIn encodes 2'b00 test, 2'b01 invert, 2'b10 clear, 2'b11 set. A test returns the operand unchanged on resultOut and leaves wbEnOut low.
- R4: The set operation returns the operand with the addressed bit at 1 and raises wbEnOut.
- R5: The clear operation returns the operand with the addressed bit at 0 and raises wbEnOut.
- R6: The invert operation returns the operand with the addressed bit inverted and raises wbEnOut.
- R7: When isRegIn is 1, the bit index is bitNumIn modulo 32, which is its low 5 bits.
- R8: When isRegIn is 0, the bit index is bitNumIn modulo 8, which is its low 3 bits, and bits 31:8 of resultOut are zero.
- R9: flagsOut bits other than bit 2 equal flagsIn as sampled with the start strobe.
- R10: resultOut, flagsOut, wbEnOut and doneOut update on the first clock edge after a start. doneOut is high for exactly that cycle, and back-to-back starts give back-to-back results. With no start, doneOut and wbEnOut stay low and resultOut holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | One-cycle request strobe |
| opIn | input | 2 | Operation code (see R3) |
| isRegIn | input | 1 | 1 for a 32-bit register operand, 0 for an 8-bit memory byte |
| operandIn | input | 32 | Operand value |
| bitNumIn | input | 8 | Bit number, from an immediate or a register |
| flagsIn | input | 5 | Current condition flags, zero flag at bit 2 |
| resultOut | output | 32 | Operand after modification |
| wbEnOut | output | 1 | Write-back enable for the result |
| flagsOut | output | 5 | Updated condition flags |
| doneOut | output | 1 | Result-valid pulse |

## Verification
Every result of this unit is due on the single clock edge that follows the start strobe: the modified operand, the write-back enable, both parts of the flag vector and the done pulse all appear together. The bench records in its own register that a start was taken at that edge. At the falling edge after it, the bench pops the expected item computed when the request was driven and compares every output. On each falling edge with no start at the preceding edge, it checks that done and write-back are low and that the result has held, so an early, late or stray output is caught.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [1:0] {
    OP_TEST = 2'b00,
    OP_FLIP = 2'b01,
    OP_CLR  = 2'b10,
    OP_SET  = 2'b11
  } bitOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic forceOne;
    logic forceZero;
    logic invert;
  } ctrlStrobe_t;

endpackage

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  bitOp_e      opIn,
  output ctrlStrobe_t strobe,
  output logic        wbEnOut,
  output logic        doneOut
);

  always_comb begin
    strobe      = '0;
    strobe.load = startIn;
    if (startIn) begin
      case (opIn)
        OP_SET:  strobe.forceOne  = 1'b1;
        OP_CLR:  strobe.forceZero = 1'b1;
        OP_FLIP: strobe.invert    = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneOut <= 1'b0;
      wbEnOut <= 1'b0;
    end else begin
      doneOut <= startIn;
      wbEnOut <= startIn && (opIn != OP_TEST);
    end
  end

endmodule

// File: rtl/bitop_datapath.sv
module bitop_datapath
  import bitop_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MEM_W    = 8,
  parameter int BITNUM_W = 8,
  parameter int FLAG_W   = 5,
  parameter int ZERO_POS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic                isRegIn,
  input  logic [DATA_W-1:0]   operandIn,
  input  logic [BITNUM_W-1:0] bitNumIn,
  input  logic [FLAG_W-1:0]   flagsIn,
  output logic [DATA_W-1:0]   resultOut,
  output logic [FLAG_W-1:0]   flagsOut
);

  localparam int IDX_W     = $clog2(DATA_W);
  localparam int MEM_IDX_W = $clog2(MEM_W);
  localparam logic [DATA_W-1:0] MEM_KEEP = {{(DATA_W-MEM_W){1'b0}}, {MEM_W{1'b1}}};

  logic [IDX_W-1:0]  bitIdx;
  logic [DATA_W-1:0] opndView;
  logic [DATA_W-1:0] bitMask;
  logic              oldBit;
  logic [DATA_W-1:0] newValue;
  logic [FLAG_W-1:0] flagsNext;

  // index wraps at the width of the operand kind
  always_comb begin
    if (isRegIn) bitIdx = bitNumIn[IDX_W-1:0];
    else         bitIdx = IDX_W'(bitNumIn[MEM_IDX_W-1:0]);
  end

  assign opndView = isRegIn ? operandIn : (operandIn & MEM_KEEP);
  assign bitMask  = DATA_W'(1) << bitIdx;
  assign oldBit   = |(opndView & bitMask);

  always_comb begin
    newValue = opndView;
    if (strobe.forceOne)       newValue = opndView | bitMask;
    else if (strobe.forceZero) newValue = opndView & ~bitMask;
    else if (strobe.invert)    newValue = opndView ^ bitMask;
  end

  for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
    if (g == ZERO_POS) begin : g_zero
      assign flagsNext[g] = ~oldBit;
    end else begin : g_pass
      assign flagsNext[g] = flagsIn[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultOut <= '0;
      flagsOut  <= '0;
    end else if (strobe.load) begin
      resultOut <= newValue;
      flagsOut  <= flagsNext;
    end
  end

endmodule

// File: rtl/bit_op_unit.sv
module bit_op_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MEM_W    = 8,
  parameter int BITNUM_W = 8,
  parameter int FLAG_W   = 5,
  parameter int ZERO_POS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startIn,
  input  logic [1:0]          opIn,
  input  logic                isRegIn,
  input  logic [DATA_W-1:0]   operandIn,
  input  logic [BITNUM_W-1:0] bitNumIn,
  input  logic [FLAG_W-1:0]   flagsIn,
  output logic [DATA_W-1:0]   resultOut,
  output logic                wbEnOut,
  output logic [FLAG_W-1:0]   flagsOut,
  output logic                doneOut
);

  ctrlStrobe_t strobe;

  bitop_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .opIn    (bitOp_e'(opIn)),
    .strobe  (strobe),
    .wbEnOut (wbEnOut),
    .doneOut (doneOut)
  );

  bitop_datapath #(
    .DATA_W   (DATA_W),
    .MEM_W    (MEM_W),
    .BITNUM_W (BITNUM_W),
    .FLAG_W   (FLAG_W),
    .ZERO_POS (ZERO_POS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .isRegIn   (isRegIn),
    .operandIn (operandIn),
    .bitNumIn  (bitNumIn),
    .flagsIn   (flagsIn),
    .resultOut (resultOut),
    .flagsOut  (flagsOut)
  );

endmodule

// File: rtl/bit_op_unit_checker.sv
module bit_op_unit_checker #(
  parameter int DATA_W   = 32,
  parameter int MEM_W    = 8,
  parameter int BITNUM_W = 8,
  parameter int FLAG_W   = 5,
  parameter int ZERO_POS = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                startIn,
  input logic [1:0]          opIn,
  input logic                isRegIn,
  input logic [DATA_W-1:0]   operandIn,
  input logic [BITNUM_W-1:0] bitNumIn,
  input logic [FLAG_W-1:0]   flagsIn,
  input logic [DATA_W-1:0]   resultOut,
  input logic                wbEnOut,
  input logic [FLAG_W-1:0]   flagsOut,
  input logic                doneOut
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [FLAG_W-1:0] OTHER_FLAGS = ~(FLAG_W'(1) << ZERO_POS);

  assert_done_follows_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> doneOut);

  assert_no_stray_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    !startIn |=> (!doneOut && !wbEnOut && $stable(resultOut)));

  assert_wb_only_with_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    wbEnOut |-> doneOut);

  assert_test_keeps_operand_R3: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && opIn == 2'b00 && isRegIn) |=> (!wbEnOut && resultOut == $past(operandIn)));

  assert_modify_writes_back_R4: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && opIn != 2'b00) |=> wbEnOut);

  assert_zero_flag_reg_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && isRegIn) |=> (flagsOut[ZERO_POS] != $past(operandIn[bitNumIn[IDX_W-1:0]])));

  assert_mem_upper_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !isRegIn) |=> (resultOut[DATA_W-1:MEM_W] == '0));

  assert_other_flags_pass_R9: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> ((flagsOut & OTHER_FLAGS) == ($past(flagsIn) & OTHER_FLAGS)));

endmodule

bind bit_op_unit bit_op_unit_checker #(
  .DATA_W   (DATA_W),
  .MEM_W    (MEM_W),
  .BITNUM_W (BITNUM_W),
  .FLAG_W   (FLAG_W),
  .ZERO_POS (ZERO_POS)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .startIn   (startIn),
  .opIn      (opIn),
  .isRegIn   (isRegIn),
  .operandIn (operandIn),
  .bitNumIn  (bitNumIn),
  .flagsIn   (flagsIn),
  .resultOut (resultOut),
  .wbEnOut   (wbEnOut),
  .flagsOut  (flagsOut),
  .doneOut   (doneOut)
);

// File: tb/bit_op_unit_tb.sv
`timescale 1ns/1ps
module bit_op_unit_tb;

  typedef struct {
    logic [31:0] res;
    logic        wb;
    logic [4:0]  flags;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [1:0]  opIn = 2'b00;
  logic        isRegIn = 1'b1;
  logic [31:0] operandIn = '0;
  logic [7:0]  bitNumIn = '0;
  logic [4:0]  flagsIn = '0;
  logic [31:0] resultOut;
  logic        wbEnOut;
  logic [4:0]  flagsOut;
  logic        doneOut;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  logic startSeen = 1'b0;
  logic [31:0] lastRes = '0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bit_op_unit u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .opIn(opIn), .isRegIn(isRegIn),
    .operandIn(operandIn), .bitNumIn(bitNumIn), .flagsIn(flagsIn),
    .resultOut(resultOut), .wbEnOut(wbEnOut), .flagsOut(flagsOut), .doneOut(doneOut)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic exp_t model(input logic [1:0] op, input logic isReg,
                                 input logic [31:0] opnd, input logic [7:0] num,
                                 input logic [4:0] flg);
    exp_t e;
    int idx;
    logic [31:0] v;
    idx = isReg ? (int'(num) % 32) : (int'(num) % 8);
    v = isReg ? opnd : {24'h0, opnd[7:0]};
    e.flags = flg;
    e.flags[2] = (v[idx] == 1'b0);
    e.wb = (op != 2'b00);
    case (op)
      2'b11: v[idx] = 1'b1;
      2'b10: v[idx] = 1'b0;
      2'b01: v[idx] = ~v[idx];
      default: ;
    endcase
    e.res = v;
    case (op)
      2'b00: e.req = "R3";
      2'b11: e.req = "R4";
      2'b10: e.req = "R5";
      default: e.req = "R6";
    endcase
    if (!isReg) e.req = {e.req, "/R8"};
    else if (num >= 8'd32) e.req = {e.req, "/R7"};
    return e;
  endfunction

  task automatic drive(input logic [1:0] op, input logic isReg, input logic [31:0] opnd,
                       input logic [7:0] num, input logic [4:0] flg);
    @(negedge clk);
    startIn = 1'b1; opIn = op; isRegIn = isReg; operandIn = opnd;
    bitNumIn = num; flagsIn = flg;
    q.push_back(model(op, isReg, opnd, num, flg));
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    startIn = 1'b0;
    operandIn = 32'hDEAD_BEEF; opIn = 2'b11; flagsIn = 5'h1F;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) startSeen <= rstN ? startIn : 1'b0;

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (startSeen) begin
          chk(doneOut == 1'b1, "R10", "done after start", {31'h0, doneOut}, 32'h1);
          if (q.size() == 0) begin
            chk(1'b0, "R10", "result with empty queue", resultOut, 32'h0);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(resultOut == e.res, e.req, "result", resultOut, e.res);
            chk(wbEnOut == e.wb, e.req, "write-back", {31'h0, wbEnOut}, {31'h0, e.wb});
            chk(flagsOut[2] == e.flags[2], "R2", "zero flag",
                {31'h0, flagsOut[2]}, {31'h0, e.flags[2]});
            chk({flagsOut[4:3], flagsOut[1:0]} == {e.flags[4:3], e.flags[1:0]}, "R9",
                "other flags", {27'h0, flagsOut}, {27'h0, e.flags});
          end
        end else begin
          chk(doneOut == 1'b0, "R10", "idle done", {31'h0, doneOut}, 32'h0);
          chk(wbEnOut == 1'b0, "R10", "idle write-back", {31'h0, wbEnOut}, 32'h0);
          chk(resultOut == lastRes, "R10", "result hold", resultOut, lastRes);
        end
        lastRes = resultOut;
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired act=%h exp=%h", 32'h0, 32'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, during and just after reset
    startIn = 1'b1;
    repeat (3) @(negedge clk);
    chk(resultOut == 0, "R1", "reset result", resultOut, 32'h0);
    chk(flagsOut == 0, "R1", "reset flags", {27'h0, flagsOut}, 32'h0);
    chk(wbEnOut == 0 && doneOut == 0, "R1", "reset strobes",
        {30'h0, wbEnOut, doneOut}, 32'h0);
    startIn = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk(resultOut == 0 && flagsOut == 0, "R1", "after release", resultOut, 32'h0);

    // directed register operations
    drive(2'b00, 1'b1, 32'h0000_0010, 8'd4, 5'b10011);   // R3 test, bit was 1
    idle(2);
    drive(2'b00, 1'b1, 32'h0000_0010, 8'd5, 5'b00000);   // R3 test, bit was 0
    idle(1);
    drive(2'b11, 1'b1, 32'h0000_0000, 8'd31, 5'b01000);  // R4 set top bit
    drive(2'b10, 1'b1, 32'hFFFF_FFFF, 8'd0, 5'b00001);   // R5 clear, back-to-back
    drive(2'b01, 1'b1, 32'hA5A5_A5A5, 8'd7, 5'b11111);   // R6 invert
    drive(2'b01, 1'b1, 32'hA5A5_A5A5, 8'd6, 5'b00100);   // R6 invert other way
    idle(2);
    // R7 index wraps at 32
    drive(2'b11, 1'b1, 32'h0, 8'd37, 5'b0);              // bit 5
    drive(2'b10, 1'b1, 32'hFFFF_FFFF, 8'd255, 5'b0);     // bit 31
    idle(1);
    // R8 memory operand: wraps at 8, upper bits zero
    drive(2'b11, 1'b0, 32'hFFFF_FF00, 8'd200, 5'b10101); // bit 0
    drive(2'b00, 1'b0, 32'h1234_5680, 8'd15, 5'b0);      // bit 7, was 1
    drive(2'b01, 1'b0, 32'hFFFF_FFFF, 8'd9, 5'b0);       // bit 1
    drive(2'b10, 1'b0, 32'h0000_0004, 8'd2, 5'b0);       // bit 2
    idle(3);

    // mixed random traffic with random gaps
    for (int i = 0; i < 80; i++) begin
      drive(2'($urandom), 1'($urandom), $urandom, 8'($urandom), 5'($urandom));
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end
    idle(4);

    chk(q.size() == 0, "R10", "all results seen", q.size(), 32'h0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule